// File: doc/BRIEF.md
# Packed Byte Unsigned Adder Unit

This execution unit treats each 32-bit source operand as four unsigned byte lanes and adds the lanes pairwise, with no carry crossing a lane boundary. One instruction variant lets each lane wrap modulo 256. The other clamps an overflowing lane to 0xFF. The packed 32-bit result is widened to a 64-bit destination value by copying its bit 31 into the upper half.

The unit decodes the instruction word itself. An encoding-select input picks one of two 32-bit layouts, and the two layouts place the two source register fields in opposite order. The unit returns the source and destination register indices, a write enable and the mode it found. It has no register file and no pipeline. It raises an illegal or disabled indication and delivers no exception.

A 32-bit control register holds a sticky overflow flag at bit 20. Any lane carry from an accepted instruction sets that flag, in either mode. Software can load the whole register through a separate write port.

Top module: `pbadd_unit`

## Requirements
- R1: In wrap mode, each of the four byte lanes (bits 7:0, 15:8, 23:16, 31:24) of dest_value[31:0] equals the matching lanes of src_a and src_b added modulo 256, and no lane affects another.
- R2: In saturating mode, a lane whose 9-bit sum exceeds 255 reads 0xFF. Every other lane reads its plain 8-bit sum.
- R3: dest_value[63:32] is 32 copies of dest_value[31].
- R4: At a clock edge, bit 20 of ctrl_reg becomes 1 when an accepted instruction has a carry out of any lane, in either mode. Without such a carry the bit keeps its value.
- R5: With enc_compact=0, a word is accepted when bits 31:26 = 011111 and bits 5:0 = 010000. Bits 10:6 = 00000 select wrap mode and 00100 select saturating mode. rs_idx comes from bits 25:21, rt_idx from bits 20:16, and dest_idx from bits 15:11.
- R6: With enc_compact=1, a word is accepted when bits 31:26 = 000000. Bits 10:0 = 00011001101 select wrap mode and 10011001101 select saturating mode. rt_idx comes from bits 25:21, rs_idx from bits 20:16, and dest_idx from bits 15:11.
- R7: While unit_en=1, a word that matches neither mode pattern for the selected layout sets illegal=1 and dest_we=0, and leaves ctrl_reg unchanged. An accepted word sets illegal=0 and dest_we=1.
- R8: While unit_en=0, disabled=1, illegal=0 and dest_we=0, and ctrl_reg does not take a flag update. While unit_en=1, disabled=0.
- R9: A synchronous active-high rst clears ctrl_reg to zero.
- R10: When sw_we=1, ctrl_reg loads sw_wdata at the clock edge. Bit 20 instead loads sw_wdata[20] ORed with the flag-set condition of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the control register |
| enc_compact | input | 1 | 1 selects the compact layout, 0 selects the standard layout |
| unit_en | input | 1 | Unit enable; 0 reports disabled and blocks all effects |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | Value of the register named by rs_idx |
| src_b | input | 32 | Value of the register named by rt_idx |
| sw_we | input | 1 | Software write strobe for the control register |
| sw_wdata | input | 32 | Software write data |
| dest_value | output | 64 | Sign-extended packed lane result |
| dest_idx | output | 5 | Destination register index |
| rs_idx | output | 5 | First source register index |
| rt_idx | output | 5 | Second source register index |
| dest_we | output | 1 | Destination write enable |
| illegal | output | 1 | Word not recognised under the selected layout |
| disabled | output | 1 | Unit disabled |
| ctrl_reg | output | 32 | Control register with the sticky flag at bit 20 |

## Verification
The only internal state is the control register, so a fault there appears on ctrl_reg one edge after the instruction that should set or hold the flag. The bench compares the whole register after every cycle. A flag that clears itself, sets without a carry, or ignores the software port is therefore caught within one clock. Faults in decode or in the lanes are combinational and appear on dest_value, the indices and the status outputs in the same cycle. The bench compares every lane against its own model, with both layouts, both modes, and carries in random lanes.

// File: rtl/pbadd_pkg.sv
package pbadd_pkg;
    localparam int INSTR_W = 32;
    localparam int IDX_W   = 5;

    localparam logic [5:0]  STD_MAJOR      = 6'b011111;
    localparam logic [5:0]  STD_FUNC       = 6'b010000;
    localparam logic [4:0]  STD_SUB_WRAP   = 5'b00000;
    localparam logic [4:0]  STD_SUB_SAT    = 5'b00100;
    localparam logic [5:0]  CMP_MAJOR      = 6'b000000;
    localparam logic [10:0] CMP_MINOR_WRAP = 11'b00011001101;
    localparam logic [10:0] CMP_MINOR_SAT  = 11'b10011001101;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_WRAP = 2'd1,
        OP_SAT  = 2'd2
    } op_kind_e;
endpackage

// File: rtl/pbadd_decode.sv
module pbadd_decode
    import pbadd_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic               enc_compact,
    output op_kind_e           op,
    output logic [IDX_W-1:0]   rs_idx,
    output logic [IDX_W-1:0]   rt_idx,
    output logic [IDX_W-1:0]   rd_idx
);
    always_comb begin
        op     = OP_NONE;
        rd_idx = instr[15:11];
        if (enc_compact) begin
            rt_idx = instr[25:21];
            rs_idx = instr[20:16];
            if (instr[31:26] == CMP_MAJOR) begin
                unique case (instr[10:0])
                    CMP_MINOR_WRAP: op = OP_WRAP;
                    CMP_MINOR_SAT:  op = OP_SAT;
                    default:        op = OP_NONE;
                endcase
            end
        end else begin
            rs_idx = instr[25:21];
            rt_idx = instr[20:16];
            if (instr[31:26] == STD_MAJOR && instr[5:0] == STD_FUNC) begin
                unique case (instr[10:6])
                    STD_SUB_WRAP: op = OP_WRAP;
                    STD_SUB_SAT:  op = OP_SAT;
                    default:      op = OP_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/pbadd_lanes.sv
module pbadd_lanes #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] a,
    input  logic [LANES*LANE_W-1:0] b,
    input  logic                    saturate,
    output logic [LANES*LANE_W-1:0] sum,
    output logic [LANES-1:0]        carry
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W:0] wide;
        assign wide     = {1'b0, a[g*LANE_W +: LANE_W]} + {1'b0, b[g*LANE_W +: LANE_W]};
        assign carry[g] = wide[LANE_W];
        assign sum[g*LANE_W +: LANE_W] =
            (saturate && wide[LANE_W]) ? {LANE_W{1'b1}} : wide[LANE_W-1:0];
    end
endmodule

// File: rtl/pbadd_ctrl_reg.sv
module pbadd_ctrl_reg #(
    parameter int CTRL_W   = 32,
    parameter int FLAG_BIT = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_we,
    input  logic [CTRL_W-1:0] sw_wdata,
    input  logic              flag_set,
    output logic [CTRL_W-1:0] ctrl_q
);
    logic [CTRL_W-1:0] ctrl_d;

    always_comb begin
        ctrl_d           = sw_we ? sw_wdata : ctrl_q;
        ctrl_d[FLAG_BIT] = ctrl_d[FLAG_BIT] | flag_set;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end
endmodule

// File: rtl/pbadd_unit.sv
module pbadd_unit
    import pbadd_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int LANE_W   = 8,
    parameter int DEST_W   = 64,
    parameter int CTRL_W   = 32,
    parameter int FLAG_BIT = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    enc_compact,
    input  logic                    unit_en,
    input  logic [INSTR_W-1:0]      instr,
    input  logic [LANES*LANE_W-1:0] src_a,
    input  logic [LANES*LANE_W-1:0] src_b,
    input  logic                    sw_we,
    input  logic [CTRL_W-1:0]       sw_wdata,
    output logic [DEST_W-1:0]       dest_value,
    output logic [IDX_W-1:0]        dest_idx,
    output logic [IDX_W-1:0]        rs_idx,
    output logic [IDX_W-1:0]        rt_idx,
    output logic                    dest_we,
    output logic                    illegal,
    output logic                    disabled,
    output logic [CTRL_W-1:0]       ctrl_reg
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int EXT_W  = DEST_W - DATA_W;

    op_kind_e          op;
    logic [DATA_W-1:0] packed_sum;
    logic [LANES-1:0]  lane_carry;
    logic              accepted;
    logic              flag_set;

    pbadd_decode u_decode (
        .instr       (instr),
        .enc_compact (enc_compact),
        .op          (op),
        .rs_idx      (rs_idx),
        .rt_idx      (rt_idx),
        .rd_idx      (dest_idx)
    );

    pbadd_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
        .a        (src_a),
        .b        (src_b),
        .saturate (op == OP_SAT),
        .sum      (packed_sum),
        .carry    (lane_carry)
    );

    always_comb begin
        accepted = unit_en && (op != OP_NONE);
        dest_we  = accepted;
        illegal  = unit_en && (op == OP_NONE);
        disabled = !unit_en;
        flag_set = accepted && (|lane_carry);
    end

    assign dest_value = {{EXT_W{packed_sum[DATA_W-1]}}, packed_sum};

    pbadd_ctrl_reg #(.CTRL_W(CTRL_W), .FLAG_BIT(FLAG_BIT)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sw_we    (sw_we),
        .sw_wdata (sw_wdata),
        .flag_set (flag_set),
        .ctrl_q   (ctrl_reg)
    );
endmodule

// File: rtl/pbadd_unit_chk.sv
module pbadd_unit_chk #(
    parameter int DEST_W   = 64,
    parameter int DATA_W   = 32,
    parameter int CTRL_W   = 32,
    parameter int FLAG_BIT = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              sw_we,
    input logic [CTRL_W-1:0] sw_wdata,
    input logic [DEST_W-1:0] dest_value,
    input logic              dest_we,
    input logic              illegal,
    input logic              disabled,
    input logic [CTRL_W-1:0] ctrl_reg
);
    localparam logic [CTRL_W-1:0] KEEP = ~(CTRL_W'(1) << FLAG_BIT);

    // R3
    sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
        dest_value[DEST_W-1:DATA_W] == {(DEST_W-DATA_W){dest_value[DATA_W-1]}});

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!sw_we && ctrl_reg[FLAG_BIT]) |=> ctrl_reg[FLAG_BIT]);

    // R7
    illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (illegal && !sw_we) |=> $stable(ctrl_reg));

    // R8
    disabled_block_chk: assert property (@(posedge clk) disable iff (rst)
        disabled |-> (!dest_we && !illegal));

    // R8
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (disabled && !sw_we) |=> $stable(ctrl_reg));

    // R10
    sw_write_chk: assert property (@(posedge clk) disable iff (rst)
        sw_we |=> ((ctrl_reg & KEEP) == ($past(sw_wdata) & KEEP)));
endmodule

bind pbadd_unit pbadd_unit_chk #(
    .DEST_W   (DEST_W),
    .DATA_W   (LANES*LANE_W),
    .CTRL_W   (CTRL_W),
    .FLAG_BIT (FLAG_BIT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sw_we      (sw_we),
    .sw_wdata   (sw_wdata),
    .dest_value (dest_value),
    .dest_we    (dest_we),
    .illegal    (illegal),
    .disabled   (disabled),
    .ctrl_reg   (ctrl_reg)
);

// File: tb/pbadd_unit_tb.sv
`timescale 1ns/1ps
module pbadd_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_compact = 1'b0;
    logic        unit_en = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [63:0] dest_value;
    logic [4:0]  dest_idx, rs_idx, rt_idx;
    logic        dest_we, illegal, disabled;
    logic [31:0] ctrl_reg;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_ctrl = '0;

    always #2 clk = ~clk;

    pbadd_unit u_dut (
        .clk(clk), .rst(rst), .enc_compact(enc_compact), .unit_en(unit_en),
        .instr(instr), .src_a(src_a), .src_b(src_b), .sw_we(sw_we),
        .sw_wdata(sw_wdata), .dest_value(dest_value), .dest_idx(dest_idx),
        .rs_idx(rs_idx), .rt_idx(rt_idx), .dest_we(dest_we), .illegal(illegal),
        .disabled(disabled), .ctrl_reg(ctrl_reg)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_std(logic [4:0] rs, logic [4:0] rt,
                                           logic [4:0] rd, bit sat);
        return {6'b011111, rs, rt, rd, sat ? 5'b00100 : 5'b00000, 6'b010000};
    endfunction

    function automatic logic [31:0] mk_cmp(logic [4:0] rs, logic [4:0] rt,
                                           logic [4:0] rd, bit sat);
        return {6'b000000, rt, rs, rd, sat ? 11'b10011001101 : 11'b00011001101};
    endfunction

    // 0 = not recognised, 1 = wrap, 2 = saturate
    function automatic int ref_mode(bit cmp, logic [31:0] w);
        if (cmp) begin
            if (w[31:26] != 6'b000000) return 0;
            if (w[10:0] == 11'b00011001101) return 1;
            if (w[10:0] == 11'b10011001101) return 2;
            return 0;
        end
        if (w[31:26] != 6'b011111 || w[5:0] != 6'b010000) return 0;
        if (w[10:6] == 5'b00000) return 1;
        if (w[10:6] == 5'b00100) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] ref_sum(logic [31:0] a, logic [31:0] b, bit sat);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) begin
            int s = int'(a[8*i +: 8]) + int'(b[8*i +: 8]);
            if (s > 255 && sat) r[8*i +: 8] = 8'hFF;
            else                r[8*i +: 8] = 8'(s);
        end
        return r;
    endfunction

    function automatic bit ref_carry(logic [31:0] a, logic [31:0] b);
        bit c = 0;
        for (int i = 0; i < 4; i++)
            if (int'(a[8*i +: 8]) + int'(b[8*i +: 8]) > 255) c = 1;
        return c;
    endfunction

    task automatic step(input bit cmp, input bit en, input logic [31:0] w,
                        input logic [31:0] a, input logic [31:0] b,
                        input bit swe, input logic [31:0] swd);
        int m;
        logic [31:0] lo;
        bit fs;
        @(negedge clk);
        enc_compact = cmp; unit_en = en; instr = w; src_a = a; src_b = b;
        sw_we = swe; sw_wdata = swd;
        #1;
        m = ref_mode(cmp, w);
        chk(disabled == !en, "R8 disabled", 64'(disabled), 64'(!en));
        if (!en) begin
            chk(!dest_we && !illegal, "R8 no write/illegal when disabled",
                {dest_we, illegal}, 64'd0);
        end else begin
            chk(illegal == (m == 0), "R7 illegal", 64'(illegal), 64'(m == 0));
            chk(dest_we == (m != 0), "R7 dest_we", 64'(dest_we), 64'(m != 0));
        end
        if (cmp) begin
            chk({rs_idx, rt_idx, dest_idx} == {w[20:16], w[25:21], w[15:11]},
                "R6 indices", {rs_idx, rt_idx, dest_idx}, {w[20:16], w[25:21], w[15:11]});
        end else begin
            chk({rs_idx, rt_idx, dest_idx} == {w[25:21], w[20:16], w[15:11]},
                "R5 indices", {rs_idx, rt_idx, dest_idx}, {w[25:21], w[20:16], w[15:11]});
        end
        if (m != 0) begin
            lo = ref_sum(a, b, m == 2);
            chk(dest_value[31:0] == lo, (m == 2) ? "R2 saturating lanes" : "R1 wrap lanes",
                dest_value[31:0], lo);
            chk(dest_value[63:32] == {32{lo[31]}}, "R3 upper extension",
                dest_value[63:32], {32{lo[31]}});
        end
        fs = en && (m != 0) && ref_carry(a, b);
        model_ctrl = swe ? swd : model_ctrl;
        model_ctrl[20] = model_ctrl[20] | fs;
        @(posedge clk);
        #1;
        chk(ctrl_reg == model_ctrl, swe ? "R10 software write" : "R4 flag update",
            ctrl_reg, model_ctrl);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk(ctrl_reg == 32'd0, "R9 reset value", ctrl_reg, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1 R2: directed lane overflows, both layouts, both modes
        step(0, 1, mk_std(5'd3, 5'd4, 5'd5, 0), 32'h01FF7F10, 32'h01018020, 0, 0);
        step(0, 1, mk_std(5'd3, 5'd4, 5'd5, 1), 32'h01FF7F10, 32'h01018020, 0, 0);
        step(1, 1, mk_cmp(5'd7, 5'd9, 5'd1, 0), 32'h80808080, 32'h80808080, 0, 0);
        step(1, 1, mk_cmp(5'd7, 5'd9, 5'd1, 1), 32'h80808080, 32'h80808080, 0, 0);
        // R10: clear via software while a carry is present (flag wins)
        step(0, 1, mk_std(5'd1, 5'd2, 5'd3, 0), 32'h000000FF, 32'h00000001, 1, 32'h0);
        // R10: clear with no carry, other bits loaded
        step(0, 1, mk_std(5'd1, 5'd2, 5'd3, 0), 32'h01020304, 32'h01010101, 1, 32'hA5A5A5A5 & ~32'h00100000);
        // R4: no carry leaves flag clear
        step(1, 1, mk_cmp(5'd2, 5'd6, 5'd8, 1), 32'h7F7F7F7F, 32'h80808080, 0, 0);
        // R7: illegal words with overflowing operands
        step(0, 1, mk_std(5'd1, 5'd2, 5'd3, 0) | 32'h00000040, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0);
        step(1, 1, mk_std(5'd1, 5'd2, 5'd3, 0), 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0);
        step(1, 1, mk_cmp(5'd1, 5'd2, 5'd3, 0) ^ 32'h00000001, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0);
        // R8: disabled with overflowing operands
        step(1, 0, mk_cmp(5'd4, 5'd5, 5'd6, 1), 32'hFF00FF00, 32'h01000100, 0, 0);
        // R4: set then hold
        step(1, 1, mk_cmp(5'd4, 5'd5, 5'd6, 0), 32'h00FF0000, 32'h00010000, 0, 0);
        step(0, 1, mk_std(5'd4, 5'd5, 5'd6, 1), 32'h00000000, 32'h00000000, 0, 0);

        for (int n = 0; n < 400; n++) begin
            bit cmp = 1'($urandom);
            bit sat = 1'($urandom);
            bit en = ($urandom % 8) != 0;
            bit swe = ($urandom % 10) == 0;
            logic [31:0] w;
            w = cmp ? mk_cmp(5'($urandom), 5'($urandom), 5'($urandom), sat)
                    : mk_std(5'($urandom), 5'($urandom), 5'($urandom), sat);
            if (($urandom % 8) == 0) w = w ^ (32'd1 << ($urandom % 32));
            step(cmp, en, w, $urandom, $urandom, swe, $urandom);
        end

        // R9: reset after activity
        @(negedge clk);
        sw_we = 1'b1; sw_wdata = 32'hFFFFFFFF; unit_en = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        sw_we = 1'b0; rst = 1'b1;
        @(posedge clk);
        #1;
        chk(ctrl_reg == 32'd0, "R9 reset clears", ctrl_reg, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule